// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block tracks loads that a scheduler has moved above earlier stores whose addresses could not be compared at compile time. When a speculative load issues, the table records its word address under the number of its destination register, and the load goes to memory as usual. Every store that follows searches the table in the same cycle. Each valid entry whose address equals the store address is marked as conflicted.

Later in program order, a check operation names the same destination register. The plain check either does nothing, when the load's data is still good, or asks for the load to be sent again and holds the pipeline until memory returns the new data. The branching check never reissues. It reports a taken branch, so that control can move to repair code. A check that finds no entry for its register is treated as a conflict, because the entry may have been pushed out. Each check frees the entry it used. The table holds a fixed number of entries. When it is full, a new load displaces the oldest one.

Top module: `spec_chk_table`

## Requirements
- R1: Out of synchronous active-low reset, `stall_o`, `reissue_o` and `br_taken_o` are low and no entry is valid.
- R2: A check with `vfy_branch_i`=0 for a register whose recorded load saw no matching store is a no-op: in the next cycle `reissue_o`, `stall_o` and `br_taken_o` all stay low.
- R3: A store whose word address equals the address of a valid entry marks that entry as conflicted. A later check with `vfy_branch_i`=0 for that register raises `reissue_o` for one cycle, with `reissue_reg_o` and `reissue_addr_o` equal to the register and address presented with the check.
- R4: A store to an address held by no entry leaves every entry unchanged.
- R5: A check for a register that has no valid entry is handled as a conflict.
- R6: A speculative load to a register that already has an entry replaces that entry's address and clears its conflict mark.
- R7: With all entries in use, a speculative load to a new register evicts the entry that was allocated longest ago. A later check for the evicted register is then handled as a conflict.
- R8: Every check, plain or branching, frees the entry it looked up, so a second check for the same register is handled as a conflict.
- R9: `stall_o` rises in the cycle after a conflicting plain check. It stays high until the cycle after `mem_ret_i` is sampled high, and then it falls.
- R10: A conflicting check with `vfy_branch_i`=1 raises `br_taken_o` for one cycle. It raises neither `reissue_o` nor `stall_o`.
- R11: Check results appear one cycle after the check is sampled, and `reissue_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sld_valid_i | input | 1 | Speculative load request |
| sld_reg_i | input | REG_W | Destination register of the speculative load |
| sld_addr_i | input | ADDR_W | Word address of the speculative load |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | ADDR_W | Word address of the store |
| vfy_valid_i | input | 1 | Check request |
| vfy_branch_i | input | 1 | 1 = branching check, 0 = reissuing check |
| vfy_reg_i | input | REG_W | Register named by the check |
| vfy_addr_i | input | ADDR_W | Address to use if the load is reissued |
| mem_ret_i | input | 1 | Reissued load data has returned |
| stall_o | output | 1 | Pipeline hold while a reissue is outstanding |
| reissue_o | output | 1 | One-cycle request to send the load again |
| reissue_reg_o | output | REG_W | Register of the reissued load |
| reissue_addr_o | output | ADDR_W | Address of the reissued load |
| br_taken_o | output | 1 | One-cycle taken result of a branching check |

## Verification
Table updates from loads and stores take effect at the edge that samples them, so their effect shows up in the result of the next check. The bench drives each request at a falling edge, lets one rising edge pass, and reads `reissue_o`, `stall_o`, `br_taken_o` and the reissue fields at the following falling edge, which is the first cycle these results are due. After a reissue, `stall_o` is sampled high at each falling edge until `mem_ret_i` has been presented for one rising edge, and it is sampled low at the falling edge right after that. The caller presents at most one request per cycle and no check while the stall is held.

// File: rtl/spec_chk_pkg.sv
// Shared types for the speculative load check table.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spec_chk_pkg;
    typedef enum logic {
        CK_RUN  = 1'b0,
        CK_WAIT = 1'b1
    } ck_state_e;
endpackage

// File: rtl/spec_chk_cam.sv
// Entry storage: register tag, word address, valid and conflict bits per slot.
// Stores snoop every slot in parallel. Assumes at most one of alloc and free
// per cycle. A store may share a cycle with neither of them (caller serialises).
module spec_chk_cam #(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 6,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic [REG_W-1:0]   alloc_reg,
    input  logic [ADDR_W-1:0]  alloc_addr,
    input  logic               st_en,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic               free_en,
    input  logic [IDX_W-1:0]   free_idx,
    input  logic [REG_W-1:0]   look_reg,
    output logic [ENTRIES-1:0] valid_o,
    output logic [ENTRIES-1:0] conflict_o,
    output logic [ENTRIES-1:0] hit_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic              valid_q;
        logic              confl_q;
        logic [REG_W-1:0]  reg_q;
        logic [ADDR_W-1:0] addr_q;

        // Slot update: allocation wins, otherwise free and store snoop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                confl_q <= 1'b0;
                reg_q   <= '0;
                addr_q  <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(g)) begin
                valid_q <= 1'b1;
                confl_q <= 1'b0;
                reg_q   <= alloc_reg;
                addr_q  <= alloc_addr;
            end else begin
                if (free_en && free_idx == IDX_W'(g)) valid_q <= 1'b0;
                if (st_en && valid_q && addr_q == st_addr) confl_q <= 1'b1;
            end
        end

        // Slot outputs for lookup and victim selection.
        always_comb begin
            valid_o[g]    = valid_q;
            conflict_o[g] = confl_q;
            hit_o[g]      = valid_q && (reg_q == look_reg);
        end

        // R8
        free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (free_en && free_idx == IDX_W'(g) && !alloc_en) |=> !valid_q);
        // R3
        store_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_en && valid_q && addr_q == st_addr && !(alloc_en && alloc_idx == IDX_W'(g)))
            |=> confl_q);
    end
endmodule

// File: rtl/spec_chk_age.sv
// Age ranking of valid slots: 0 = newest, count-1 = oldest. It names the oldest
// slot as the victim. Assumes ENTRIES is a power of two and that valid_i
// comes from the storage this module shadows.
module spec_chk_age #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               alloc_en,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic               free_en,
    input  logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   victim_o
);
    logic [IDX_W-1:0] age_q [ENTRIES];

    // Rank update: a new slot becomes rank 0, a freed slot closes its gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < ENTRIES; j++) age_q[j] <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (IDX_W'(j) == alloc_idx)
                    age_q[j] <= '0;
                else if (valid_i[j] && (!valid_i[alloc_idx] || age_q[j] < age_q[alloc_idx]))
                    age_q[j] <= age_q[j] + IDX_W'(1);
            end
        end else if (free_en) begin
            for (int j = 0; j < ENTRIES; j++)
                if (valid_i[j] && age_q[j] > age_q[free_idx])
                    age_q[j] <= age_q[j] - IDX_W'(1);
        end
    end

    // Victim: the valid slot carrying the top rank.
    always_comb begin
        victim_o = '0;
        for (int j = 0; j < ENTRIES; j++)
            if (valid_i[j] && age_q[j] == IDX_W'(ENTRIES - 1)) victim_o = IDX_W'(j);
    end

    // R7
    full_victim_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_i) |-> (valid_i[victim_o] && age_q[victim_o] == IDX_W'(ENTRIES - 1)));
    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        // R7
        rank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i[g] |-> (int'(age_q[g]) < $countones(valid_i)));
    end
endmodule

// File: rtl/spec_chk_ctrl.sv
// Check result sequencing. It pulses reissue or branch-taken one cycle after
// a conflicting check and holds stall until the reissued data returns. Assumes
// no check is presented while stall is high.
module spec_chk_ctrl #(
    parameter int REG_W  = 6,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vfy_en,
    input  logic              vfy_br,
    input  logic              vfy_conf,
    input  logic [REG_W-1:0]  vfy_reg,
    input  logic [ADDR_W-1:0] vfy_addr,
    input  logic              mem_ret,
    output logic              stall_o,
    output logic              reissue_o,
    output logic [REG_W-1:0]  reissue_reg_o,
    output logic [ADDR_W-1:0] reissue_addr_o,
    output logic              br_taken_o
);
    import spec_chk_pkg::*;

    ck_state_e state_q;
    logic      redo;

    assign redo    = vfy_en && !vfy_br && vfy_conf;
    assign stall_o = (state_q == CK_WAIT);

    // Result pulses and reissue operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reissue_o      <= 1'b0;
            br_taken_o     <= 1'b0;
            reissue_reg_o  <= '0;
            reissue_addr_o <= '0;
        end else begin
            reissue_o  <= redo;
            br_taken_o <= vfy_en && vfy_br && vfy_conf;
            if (vfy_en) begin
                reissue_reg_o  <= vfy_reg;
                reissue_addr_o <= vfy_addr;
            end
        end
    end

    // Stall state: enter on reissue, leave on returned data.
    always_ff @(posedge clk) begin
        if (!rst_n)                          state_q <= CK_RUN;
        else if (state_q == CK_RUN && redo)  state_q <= CK_WAIT;
        else if (state_q == CK_WAIT && mem_ret) state_q <= CK_RUN;
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !mem_ret) |=> stall_o);
    // R9
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && mem_ret) |=> !stall_o);
    // R3
    reissue_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_o |-> stall_o);
    // R10
    branch_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |-> (!stall_o && !reissue_o));
    // R11
    reissue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_o |=> !reissue_o);
endmodule

// File: rtl/spec_chk_table.sv
// Top of the speculative load check table. It picks the slot for each load
// (same register, else a free slot, else the oldest), resolves each check
// against the stored tags, and hands the result to the sequencer.
// Assumes at most one of load, store and check per cycle.
module spec_chk_table #(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 6,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sld_valid_i,
    input  logic [REG_W-1:0]  sld_reg_i,
    input  logic [ADDR_W-1:0] sld_addr_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              vfy_valid_i,
    input  logic              vfy_branch_i,
    input  logic [REG_W-1:0]  vfy_reg_i,
    input  logic [ADDR_W-1:0] vfy_addr_i,
    input  logic              mem_ret_i,
    output logic              stall_o,
    output logic              reissue_o,
    output logic [REG_W-1:0]  reissue_reg_o,
    output logic [ADDR_W-1:0] reissue_addr_o,
    output logic              br_taken_o
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid, conflict, hit;
    logic [REG_W-1:0]   look_reg;
    logic [IDX_W-1:0]   hit_idx, free_slot, victim, alloc_idx;
    logic               any_free, any_hit, vfy_conf;

    assign look_reg = sld_valid_i ? sld_reg_i : vfy_reg_i;
    assign any_hit  = |hit;
    assign any_free = ~&valid;
    assign vfy_conf = !any_hit || |(hit & conflict);

    // Encode the matching slot and the lowest free slot.
    always_comb begin
        hit_idx   = '0;
        free_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i])    hit_idx   = IDX_W'(i);
            if (!valid[i]) free_slot = IDX_W'(i);
        end
    end

    // Slot choice for a speculative load.
    always_comb begin
        if (any_hit)       alloc_idx = hit_idx;
        else if (any_free) alloc_idx = free_slot;
        else               alloc_idx = victim;
    end

    spec_chk_cam #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (sld_valid_i),
        .alloc_idx  (alloc_idx),
        .alloc_reg  (sld_reg_i),
        .alloc_addr (sld_addr_i),
        .st_en      (st_valid_i),
        .st_addr    (st_addr_i),
        .free_en    (vfy_valid_i && any_hit),
        .free_idx   (hit_idx),
        .look_reg   (look_reg),
        .valid_o    (valid),
        .conflict_o (conflict),
        .hit_o      (hit)
    );

    spec_chk_age #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid),
        .alloc_en  (sld_valid_i),
        .alloc_idx (alloc_idx),
        .free_en   (vfy_valid_i && any_hit),
        .free_idx  (hit_idx),
        .victim_o  (victim)
    );

    spec_chk_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .vfy_en         (vfy_valid_i),
        .vfy_br         (vfy_branch_i),
        .vfy_conf       (vfy_conf),
        .vfy_reg        (vfy_reg_i),
        .vfy_addr       (vfy_addr_i),
        .mem_ret        (mem_ret_i),
        .stall_o        (stall_o),
        .reissue_o      (reissue_o),
        .reissue_reg_o  (reissue_reg_o),
        .reissue_addr_o (reissue_addr_o),
        .br_taken_o     (br_taken_o)
    );

    // R6
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R5
    miss_is_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vfy_valid_i && !vfy_branch_i && !any_hit) |=> reissue_o);
endmodule

// File: tb/spec_chk_table_tb.sv
module spec_chk_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int RW = 6;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sld_valid_i = 0, st_valid_i = 0, vfy_valid_i = 0, vfy_branch_i = 0, mem_ret_i = 0;
    logic [RW-1:0] sld_reg_i = '0, vfy_reg_i = '0;
    logic [AW-1:0] sld_addr_i = '0, st_addr_i = '0, vfy_addr_i = '0;
    logic stall_o, reissue_o, br_taken_o;
    logic [RW-1:0] reissue_reg_o;
    logic [AW-1:0] reissue_addr_o;

    int checks = 0;
    int errors = 0;

    // Reference table
    bit          m_valid [NE];
    bit          m_conf  [NE];
    int          m_reg   [NE];
    int          m_addr  [NE];
    int          m_stamp [NE];
    int          stamp_ctr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_chk_table #(.ENTRIES(NE), .REG_W(RW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sld_valid_i(sld_valid_i), .sld_reg_i(sld_reg_i), .sld_addr_i(sld_addr_i),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
        .vfy_valid_i(vfy_valid_i), .vfy_branch_i(vfy_branch_i),
        .vfy_reg_i(vfy_reg_i), .vfy_addr_i(vfy_addr_i), .mem_ret_i(mem_ret_i),
        .stall_o(stall_o), .reissue_o(reissue_o), .reissue_reg_o(reissue_reg_o),
        .reissue_addr_o(reissue_addr_o), .br_taken_o(br_taken_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_find(input int r);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_reg[i] == r) return i;
        return -1;
    endfunction

    function automatic void m_load(input int r, input int a);
        int s = m_find(r);
        if (s < 0) for (int i = NE - 1; i >= 0; i--) if (!m_valid[i]) s = i;
        if (s < 0) begin
            s = 0;
            for (int i = 1; i < NE; i++) if (m_stamp[i] < m_stamp[s]) s = i;
        end
        m_valid[s] = 1; m_conf[s] = 0; m_reg[s] = r; m_addr[s] = a;
        stamp_ctr++; m_stamp[s] = stamp_ctr;
    endfunction

    function automatic void m_store(input int a);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_addr[i] == a) m_conf[i] = 1;
    endfunction

    // Returns expected conflict and frees the entry.
    function automatic bit m_check(input int r);
        int s = m_find(r);
        if (s < 0) return 1;
        m_valid[s] = 0;
        return m_conf[s];
    endfunction

    task automatic do_sld(input int r, input int a);
        sld_valid_i = 1; sld_reg_i = RW'(r); sld_addr_i = AW'(a);
        @(posedge clk); m_load(r, a);
        @(negedge clk); sld_valid_i = 0;
    endtask

    task automatic do_st(input int a);
        st_valid_i = 1; st_addr_i = AW'(a);
        @(posedge clk); m_store(a);
        @(negedge clk); st_valid_i = 0;
    endtask

    task automatic do_vfy(input bit br, input int r, input int a, input string req);
        bit c;
        vfy_valid_i = 1; vfy_branch_i = br; vfy_reg_i = RW'(r); vfy_addr_i = AW'(a);
        @(posedge clk); c = m_check(r);
        @(negedge clk); vfy_valid_i = 0; vfy_branch_i = 0;
        // R11: results sampled one cycle after the check
        chk(reissue_o == (c && !br), {req, "/R11 reissue"}, reissue_o, c && !br);
        chk(stall_o == (c && !br), {req, " stall"}, stall_o, c && !br);
        chk(br_taken_o == (c && br), {req, "/R10 branch"}, br_taken_o, c && br);
        if (c && !br) begin
            chk(reissue_reg_o == RW'(r), {req, "/R3 reg"}, reissue_reg_o, r);
            chk(reissue_addr_o == AW'(a), {req, "/R3 addr"}, reissue_addr_o, a);
            for (int k = 0; k < int'($urandom % 4); k++) begin
                @(posedge clk); @(negedge clk);
                chk(stall_o == 1, "R9 hold", stall_o, 1);
                chk(reissue_o == 0, "R11 pulse", reissue_o, 0);
            end
            mem_ret_i = 1;
            @(posedge clk); @(negedge clk); mem_ret_i = 0;
            chk(stall_o == 0, "R9 release", stall_o, 0);
            chk(reissue_o == 0, "R11 pulse", reissue_o, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_conf[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(stall_o == 0, "R1 stall", stall_o, 0);
        chk(reissue_o == 0, "R1 reissue", reissue_o, 0);
        chk(br_taken_o == 0, "R1 branch", br_taken_o, 0);
        do_vfy(0, 3, 77, "R1/R5 empty");
        // R2
        do_sld(1, 100); do_vfy(0, 1, 100, "R2");
        // R4
        do_sld(2, 200); do_st(201); do_vfy(0, 2, 200, "R4");
        // R3
        do_sld(2, 200); do_st(200); do_vfy(0, 2, 200, "R3");
        // R6
        do_sld(4, 50); do_st(50); do_sld(4, 60); do_vfy(0, 4, 60, "R6");
        // R8
        do_sld(5, 9); do_vfy(0, 5, 9, "R8 first"); do_vfy(0, 5, 9, "R8 second");
        // R7
        for (int i = 0; i < NE; i++) do_sld(10 + i, 300 + i);
        do_sld(30, 400);
        do_vfy(0, 11, 301, "R7 kept");
        do_vfy(0, 10, 300, "R7 evicted");
        for (int i = 12; i < 10 + NE; i++) do_vfy(0, i, 300 + i - 10, "R7 rest");
        do_vfy(0, 30, 400, "R7 newest");
        // R10
        do_sld(6, 7); do_st(7); do_vfy(1, 6, 7, "R10 taken");
        do_vfy(1, 6, 7, "R10/R8 gone");
        do_sld(6, 8); do_vfy(1, 6, 8, "R10 not taken");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 12);
            int a = int'($urandom % 16);
            case ($urandom % 6)
                0, 1: do_sld(r, a);
                2, 3: do_st(a);
                4: do_vfy(0, r, a, "R3/R2 random");
                default: do_vfy(1, r, a, "R10 random");
            endcase
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule